// File: doc/BRIEF.md
# Accumulator Fetch-Execute Processor Core

This block is a small processor core with one accumulator. A control sequencer runs every instruction through the same fixed fetch sequence, then a decode step, then an execute step. The fetch uses explicit program counter, memory address, memory buffer and current instruction registers. After decode, an instruction can take an optional operand read, and then it executes. The core drives a synchronous, word-addressed memory through a registered address, a write-data output and a one-cycle write-enable. The memory returns read data one clock after it samples the address.

Each instruction word has an opcode field and an operand field. Depending on the opcode, the operand is used as an immediate value, as the memory address of a data word, or as a branch target. A three-bit status register holds zero, negative and carry flags. Conditional branches test these flags. A halt instruction freezes the core until the next reset.

Top module: `acc_fe_core`

## Requirements
- R1: A synchronous reset (`rst` high at a rising edge) clears the program counter, memory address register, accumulator and flags to zero. While reset is held, `halted` and `mem_we` are low and `mem_addr` is 0.
- R2: Every instruction starts with the same four-cycle fetch:
  - the memory address register is loaded from the program counter;
  - one wait cycle follows;
  - the program counter increments by one and the memory buffer register is loaded from memory, in the same cycle;
  - the instruction register is loaded from the memory buffer register.
  A decode cycle follows. Instructions that read a data operand then take two more cycles (wait, capture). Every instruction ends with one execute cycle. An instruction therefore takes 8 cycles with a memory read and 6 cycles without one.
- R3: The instruction word is 8 bits. Bits 7:4 are the opcode and bits 3:0 are the operand. The opcodes are: 0 halt, 1 load from address, 2 store to address, 3 add, 4 subtract, 5 AND, 6 OR (3 to 6 take their operand from memory), 7 load immediate, 8 branch, 9 branch if zero.
- R4: Load from address copies the addressed memory word into the accumulator. Load immediate writes the zero-extended operand into the accumulator.
- R5: Add sets the accumulator to the 8-bit sum of the accumulator and the addressed word, with carry set to the carry out. Subtract sets the accumulator to the accumulator minus the addressed word, with carry set when a borrow occurs (accumulator less than the word).
- R6: AND and OR combine the accumulator bitwise with the addressed word and write the result back into the accumulator.
- R7: Store writes the accumulator to the operand address. `mem_we` is high for exactly one cycle, with `mem_addr` equal to the operand and `mem_wdata` equal to the accumulator.
- R8: Branch loads the program counter with the operand. Branch if zero does so only when the zero flag is set; otherwise execution continues at the next word.
- R9: `flags_out` is {zero (bit 2), negative (bit 1), carry (bit 0)}. Add and subtract update all three flags. AND, OR and both loads update zero and negative and clear carry. Store and both branches leave the flags unchanged.
- R10: Opcodes 10 to 15 do nothing: no accumulator, flag or memory change, and no write cycle.
- R11: After the execute cycle of a halt, `halted` rises and stays high until reset. No further memory write occurs and the accumulator holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| mem_addr | output | ADR_W (4) | Word address to memory, driven by the memory address register |
| mem_rdata | input | 4+ADR_W (8) | Read data, valid one cycle after the address is sampled |
| mem_wdata | output | 4+ADR_W (8) | Write data from the memory buffer register |
| mem_we | output | 1 | Write strobe for one cycle of a store |
| halted | output | 1 | High once a halt has executed |
| acc_out | output | 4+ADR_W (8) | Accumulator contents |
| flags_out | output | 3 | {zero, negative, carry} |

## Verification
The bench builds the core with its default 4-bit operand field. This gives an 8-bit data word and a 16-word memory, so a whole program and its data fit into one small image that is reloaded for each run. At this size, every arithmetic and logic opcode can be swept over a 16-by-16 grid of operand values that includes 0, 255, equal pairs and both carry and borrow edges. In the same setup, every immediate value drives the conditional branch both ways, and every unused opcode is paired with every operand. Each run is timed from reset to halt against the cycle counts of the fetch sequence.

// File: rtl/acc_fe_pkg.sv
package acc_fe_pkg;

   localparam int OPC_W = 4;

   localparam logic [OPC_W-1:0] OPC_HALT  = 4'h0;
   localparam logic [OPC_W-1:0] OPC_LOAD  = 4'h1;
   localparam logic [OPC_W-1:0] OPC_STORE = 4'h2;
   localparam logic [OPC_W-1:0] OPC_ADD   = 4'h3;
   localparam logic [OPC_W-1:0] OPC_SUB   = 4'h4;
   localparam logic [OPC_W-1:0] OPC_AND   = 4'h5;
   localparam logic [OPC_W-1:0] OPC_OR    = 4'h6;
   localparam logic [OPC_W-1:0] OPC_LDI   = 4'h7;
   localparam logic [OPC_W-1:0] OPC_JMP   = 4'h8;
   localparam logic [OPC_W-1:0] OPC_JZ    = 4'h9;

   typedef enum logic [3:0] {
      ST_F1   = 4'd0,  // address register takes program counter
      ST_FW   = 4'd1,  // memory samples address
      ST_F2   = 4'd2,  // counter step and buffer capture
      ST_F3   = 4'd3,  // instruction register takes buffer
      ST_DEC  = 4'd4,
      ST_OPW  = 4'd5,
      ST_OPR  = 4'd6,
      ST_EXE  = 4'd7,
      ST_HALT = 4'd8
   } seq_state_e;

   typedef struct packed {
      logic z;
      logic n;
      logic c;
   } flags_t;

   function automatic logic reads_operand(input logic [OPC_W-1:0] opc);
      return (opc == OPC_LOAD) || (opc == OPC_ADD) || (opc == OPC_SUB) ||
             (opc == OPC_AND)  || (opc == OPC_OR);
   endfunction

endpackage

// File: rtl/acc_fe_seq.sv
module acc_fe_seq
   import acc_fe_pkg::*;
(
   input  logic             clk,
   input  logic             rst,
   input  logic [OPC_W-1:0] opc,
   output seq_state_e       state
);

   seq_state_e nxt;

   always_comb begin
      nxt = state;
      unique case (state)
         ST_F1:   nxt = ST_FW;
         ST_FW:   nxt = ST_F2;
         ST_F2:   nxt = ST_F3;
         ST_F3:   nxt = ST_DEC;
         ST_DEC:  nxt = reads_operand(opc) ? ST_OPW : ST_EXE;
         ST_OPW:  nxt = ST_OPR;
         ST_OPR:  nxt = ST_EXE;
         ST_EXE:  nxt = (opc == OPC_HALT) ? ST_HALT : ST_F1;
         ST_HALT: nxt = ST_HALT;
         default: nxt = ST_F1;
      endcase
   end

   always_ff @(posedge clk) begin
      if (rst) state <= ST_F1;
      else     state <= nxt;
   end

endmodule

// File: rtl/acc_fe_alu.sv
module acc_fe_alu
   import acc_fe_pkg::*;
#(
   parameter int ADR_W = 4,
   localparam int DATA_W = OPC_W + ADR_W
) (
   input  logic [OPC_W-1:0]  opc,
   input  logic [DATA_W-1:0] acc,
   input  logic [DATA_W-1:0] mbr,
   input  logic [ADR_W-1:0]  opr,
   input  flags_t            flg_in,
   output logic [DATA_W-1:0] res,
   output flags_t            flg_out,
   output logic              acc_wr
);

   logic [DATA_W:0] sum_x;
   logic [DATA_W:0] dif_x;
   logic            arith;

   assign sum_x = {1'b0, acc} + {1'b0, mbr};
   assign dif_x = {1'b0, acc} - {1'b0, mbr};

   always_comb begin
      res    = acc;
      acc_wr = 1'b1;
      arith  = 1'b0;
      case (opc)
         OPC_LOAD: res = mbr;
         OPC_LDI:  res = {{OPC_W{1'b0}}, opr};
         OPC_ADD:  begin res = sum_x[DATA_W-1:0]; arith = 1'b1; end
         OPC_SUB:  begin res = dif_x[DATA_W-1:0]; arith = 1'b1; end
         OPC_AND:  res = acc & mbr;
         OPC_OR:   res = acc | mbr;
         default:  acc_wr = 1'b0;
      endcase
   end

   always_comb begin
      flg_out = flg_in;
      if (acc_wr) begin
         flg_out.z = (res == '0);
         flg_out.n = res[DATA_W-1];
         flg_out.c = 1'b0;
         if (arith)
            flg_out.c = (opc == OPC_ADD) ? sum_x[DATA_W] : dif_x[DATA_W];
      end
   end

endmodule

// File: rtl/acc_fe_core.sv
module acc_fe_core
   import acc_fe_pkg::*;
#(
   parameter int ADR_W = 4,
   localparam int DATA_W = OPC_W + ADR_W
) (
   input  logic              clk,
   input  logic              rst,
   output logic [ADR_W-1:0]  mem_addr,
   input  logic [DATA_W-1:0] mem_rdata,
   output logic [DATA_W-1:0] mem_wdata,
   output logic              mem_we,
   output logic              halted,
   output logic [DATA_W-1:0] acc_out,
   output logic [2:0]        flags_out
);

   if (ADR_W < 2 || ADR_W > 12) begin : g_bad_width
      $error("acc_fe_core: ADR_W must lie in 2..12");
   end

   seq_state_e        state;
   logic [ADR_W-1:0]  pc_q, mar_q;
   logic [DATA_W-1:0] mbr_q, cir_q, acc_q;
   flags_t            flags_q;

   logic [OPC_W-1:0]  opc;
   logic [ADR_W-1:0]  opr;
   logic [DATA_W-1:0] alu_res;
   flags_t            alu_flg;
   logic              alu_wr;

   assign opc = cir_q[DATA_W-1 -: OPC_W];
   assign opr = cir_q[ADR_W-1:0];

   acc_fe_seq u_seq (
      .clk   (clk),
      .rst   (rst),
      .opc   (opc),
      .state (state)
   );

   acc_fe_alu #(.ADR_W(ADR_W)) u_alu (
      .opc     (opc),
      .acc     (acc_q),
      .mbr     (mbr_q),
      .opr     (opr),
      .flg_in  (flags_q),
      .res     (alu_res),
      .flg_out (alu_flg),
      .acc_wr  (alu_wr)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         pc_q    <= '0;
         mar_q   <= '0;
         mbr_q   <= '0;
         cir_q   <= '0;
         acc_q   <= '0;
         flags_q <= '0;
      end else begin
         case (state)
            ST_F1: mar_q <= pc_q;
            ST_F2: begin
               pc_q  <= pc_q + 1'b1;
               mbr_q <= mem_rdata;
            end
            ST_F3: cir_q <= mbr_q;
            ST_DEC: begin
               if (reads_operand(opc) || opc == OPC_STORE) mar_q <= opr;
               if (opc == OPC_STORE) mbr_q <= acc_q;
            end
            ST_OPR: mbr_q <= mem_rdata;
            ST_EXE: begin
               if (alu_wr) begin
                  acc_q   <= alu_res;
                  flags_q <= alu_flg;
               end
               if (opc == OPC_JMP || (opc == OPC_JZ && flags_q.z)) pc_q <= opr;
            end
            default: ;
         endcase
      end
   end

   assign mem_addr  = mar_q;
   assign mem_wdata = mbr_q;
   assign mem_we    = (state == ST_EXE) && (opc == OPC_STORE);
   assign halted    = (state == ST_HALT);
   assign acc_out   = acc_q;
   assign flags_out = flags_q;

endmodule

// File: rtl/acc_fe_chk.sv
module acc_fe_chk
   import acc_fe_pkg::*;
#(
   parameter int ADR_W = 4,
   localparam int DATA_W = OPC_W + ADR_W
) (
   input logic              clk,
   input logic              rst,
   input seq_state_e        state,
   input logic [ADR_W-1:0]  pc,
   input logic [ADR_W-1:0]  mar,
   input logic [DATA_W-1:0] mbr,
   input logic [DATA_W-1:0] cir,
   input logic [DATA_W-1:0] acc,
   input logic [2:0]        flags,
   input logic              mem_we,
   input logic [DATA_W-1:0] mem_wdata,
   input logic              halted
);

   p_mar_from_pc_r2: assert property (@(posedge clk) disable iff (rst)
      (state == ST_F1) |=> (mar == $past(pc)));

   p_pc_step_r2: assert property (@(posedge clk) disable iff (rst)
      (state == ST_F2) |=> (pc == $past(pc) + ADR_W'(1)));

   p_cir_load_r2: assert property (@(posedge clk) disable iff (rst)
      (state == ST_F3) |=> (cir == $past(mbr)));

   p_we_pulse_r7: assert property (@(posedge clk) disable iff (rst)
      mem_we |=> !mem_we);

   p_wdata_acc_r7: assert property (@(posedge clk) disable iff (rst)
      mem_we |-> (mem_wdata == acc));

   p_flags_keep_store_r9: assert property (@(posedge clk) disable iff (rst)
      mem_we |=> (flags == $past(flags)));

   p_halt_sticky_r11: assert property (@(posedge clk) disable iff (rst)
      halted |=> halted);

   p_halt_quiet_r11: assert property (@(posedge clk) disable iff (rst)
      halted |-> !mem_we);

   p_halt_hold_r11: assert property (@(posedge clk) disable iff (rst)
      halted |=> $stable(acc));

endmodule

bind acc_fe_core acc_fe_chk #(.ADR_W(ADR_W)) u_chk (
   .clk       (clk),
   .rst       (rst),
   .state     (state),
   .pc        (pc_q),
   .mar       (mar_q),
   .mbr       (mbr_q),
   .cir       (cir_q),
   .acc       (acc_q),
   .flags     (flags_q),
   .mem_we    (mem_we),
   .mem_wdata (mem_wdata),
   .halted    (halted)
);

// File: tb/tb_acc_fe_core.sv
module tb_acc_fe_core;

   localparam int AW = 4;
   localparam int DW = 8;
   localparam int NW = 1 << AW;

   logic          clk = 1'b0;
   logic          rst = 1'b1;
   logic [AW-1:0] mem_addr;
   logic [DW-1:0] mem_rdata;
   logic [DW-1:0] mem_wdata;
   logic          mem_we;
   logic          halted;
   logic [DW-1:0] acc_out;
   logic [2:0]    flags_out;

   logic [DW-1:0] mem [NW];
   logic [DW-1:0] img [NW];
   logic          ld = 1'b0;

   int checks = 0;
   int errors = 0;
   bit done   = 1'b0;

   always #5 clk = ~clk;

   acc_fe_core #(.ADR_W(AW)) dut (
      .clk(clk), .rst(rst), .mem_addr(mem_addr), .mem_rdata(mem_rdata),
      .mem_wdata(mem_wdata), .mem_we(mem_we), .halted(halted),
      .acc_out(acc_out), .flags_out(flags_out)
   );

   always @(posedge clk) begin
      if (ld) begin
         for (int i = 0; i < NW; i++) mem[i] <= img[i];
      end else if (mem_we) begin
         mem[mem_addr] <= mem_wdata;
      end
      mem_rdata <= mem[mem_addr];
   end

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   task automatic clear_img();
      for (int i = 0; i < NW; i++) img[i] = 8'hEE;
   endtask

   int run_cyc;
   int run_wr;

   // reset, load image, release, run to halt, then watch a quiet tail
   task automatic run_prog();
      bit quiet;
      @(negedge clk);
      rst = 1'b1;
      ld  = 1'b1;
      @(negedge clk);
      ld  = 1'b0;
      @(negedge clk);
      chk("R1 reset acc", acc_out, 0);
      chk("R1 reset flags", flags_out, 0);
      chk("R1 reset halted/we/addr", {halted, mem_we, mem_addr}, 0);
      rst = 1'b0;
      run_cyc = 0;
      run_wr  = 0;
      while (!halted && run_cyc < 400) begin
         @(negedge clk);
         run_cyc++;
         if (mem_we) run_wr++;
      end
      quiet = 1'b1;
      for (int k = 0; k < 4; k++) begin
         @(negedge clk);
         if (!halted || mem_we) quiet = 1'b0;
      end
      chk("R11 halt sticky and quiet", quiet, 1);
   endtask

   // expected {flags, acc} after op with accumulator a and memory word b
   function automatic logic [10:0] model(input logic [3:0] op, input logic [7:0] a,
                                         input logic [7:0] b);
      logic [8:0] w;
      logic       c;
      c = 1'b0;
      case (op)
         4'h1: w = {1'b0, b};
         4'h3: begin w = {1'b0, a} + {1'b0, b}; c = w[8]; end
         4'h4: begin w = {1'b0, a} - {1'b0, b}; c = (a < b); end
         4'h5: w = {1'b0, a & b};
         4'h6: w = {1'b0, a | b};
         default: w = {1'b0, a};
      endcase
      return {(w[7:0] == 8'h00), w[7], c, w[7:0]};
   endfunction

   initial begin
      logic [3:0]  ops [5];
      logic [10:0] e;
      string       rq;
      ops[0] = 4'h1; ops[1] = 4'h3; ops[2] = 4'h4; ops[3] = 4'h5; ops[4] = 4'h6;

      // sweep: LOAD 14; <op> 15; STORE 13; HALT   (R3 field layout op[7:4], addr[3:0])
      for (int o = 0; o < 5; o++) begin
         for (int i = 0; i < 16; i++) begin
            for (int j = 0; j < 16; j++) begin
               clear_img();
               img[0]  = 8'h1E;
               img[1]  = {ops[o], 4'hF};
               img[2]  = 8'h2D;
               img[3]  = 8'h00;
               img[14] = 8'(i * 17);
               img[15] = 8'(j * 17);
               run_prog();
               e = model(ops[o], img[14], img[15]);
               rq = (ops[o] == 4'h1) ? "R3 R4" :
                    (ops[o] == 4'h3 || ops[o] == 4'h4) ? "R3 R5" : "R3 R6";
               chk({rq, " acc"}, acc_out, e[7:0]);
               chk("R9 flags", flags_out, e[10:8]);
               chk("R7 stored word", mem[13], e[7:0]);
               chk("R7 write cycles", run_wr, 1);
               chk("R2 cycles to halt", run_cyc, 28);
            end
         end
      end

      // branches: LDI v; JZ 4; LDI 1; JMP 5; LDI 2; STORE 12; HALT
      for (int v = 0; v < 16; v++) begin
         clear_img();
         img[0] = {4'h7, 4'(v)};
         img[1] = 8'h94;
         img[2] = 8'h71;
         img[3] = 8'h85;
         img[4] = 8'h72;
         img[5] = 8'h2C;
         img[6] = 8'h00;
         run_prog();
         chk("R8 branch result", mem[12], (v == 0) ? 2 : 1);
         chk("R4 immediate acc", acc_out, (v == 0) ? 2 : 1);
         chk("R8 cycles to halt", run_cyc, (v == 0) ? 30 : 36);
         chk("R9 flags after immediate", flags_out, 0);
      end

      // undefined opcodes: LOAD 14 (FF); ADD 15 (01); <op,opr>; HALT
      for (int op = 10; op < 16; op++) begin
         for (int a = 0; a < 16; a++) begin
            clear_img();
            img[0]  = 8'h1E;
            img[1]  = 8'h3F;
            img[2]  = {4'(op), 4'(a)};
            img[3]  = 8'h00;
            img[14] = 8'hFF;
            img[15] = 8'h01;
            run_prog();
            chk("R10 acc unchanged", acc_out, 0);
            chk("R10 R5 flags z,c kept", flags_out, 3'b101);
            chk("R10 no write", run_wr, 0);
            chk("R10 memory intact", mem[a], img[a]);
            chk("R10 cycles", run_cyc, 28);
         end
      end

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (190000) @(posedge clk);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

endmodule